// File: doc/BRIEF.md
# Dual-Source Serial Audio Input Switch with One-Frame Re-Transmit

This block receives two independent serial stereo audio streams in the common I2S format. Each stream has its own bit clock, word-select line and data line. A control input chooses which stream is live. The selected bit clock and word select are forwarded to shared outputs, and the block regenerates them there. Every stereo sample captured from the live stream is held for one frame. It is then shifted out again, aligned to the forwarded clocks, on several identical serial data outputs.

All logic runs on a fast internal clock that oversamples the serial lines. The serial inputs pass through a synchronizer, and clock edges are found by comparing successive samples. Captured words are left-justified into an 18-bit holding slot. Output-enable pins are produced for the forwarded clocks and for each data output, so the pads can be tri-stated outside the block.

Top module: `i2s_dual_retx`

## Requirements
- R1: After reset the clock-enable output is 1, `sd_oe` is 3'b011, all data outputs are 0, and input A is the live source.
- R2: A word-select level of 0 marks a left word and 1 marks a right word. On input and output alike, the MSB of a word comes one bit-clock period after the word-select change.
- R3: Data outputs change only in the fast-clock cycle in which `bck_out` falls. A receiver samples them on the rising edge.
- R4: An input word shorter than 18 bits is sent MSB-aligned, with zeros in every following bit position of the output slot.
- R5: An input word of 18 bits or more keeps its 18 most significant bits. The rest of the output slot is zero.
- R6: When `sel_b` is 0, input A is captured and forwarded. When it is 1, input B is. The unselected input has no effect on any output.
- R7: `bck_out` and `ws_out` repeat the selected input's bit clock and word select, delayed by exactly 3 fast-clock cycles.
- R8: The left/right pair captured in frame n is sent in frame n+1. The first output frame after reset carries zeros.
- R9: `clk_oe` is 0 one cycle after `clk_out_dis` is 1, and 1 one cycle after it is 0.
- R10: `sd_oe[2]` follows `sd_last_en` with one cycle of latency. `sd_oe[1:0]` stay 1.
- R11: After `sel_b` changes, the data outputs carry zeros until a complete left/right frame from the new source has been captured.
- R12: All three data outputs carry identical data at all times.
- R13: Capture and re-transmit are correct with a bit-clock half period of 2 fast-clock cycles, which is a ratio of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_bck | input | 1 | Input A bit clock |
| src_a_ws | input | 1 | Input A word select |
| src_a_sd | input | 1 | Input A serial data |
| src_b_bck | input | 1 | Input B bit clock |
| src_b_ws | input | 1 | Input B word select |
| src_b_sd | input | 1 | Input B serial data |
| sel_b | input | 1 | 0 selects input A, 1 selects input B |
| clk_out_dis | input | 1 | 1 tri-states forwarded bit clock and word select |
| sd_last_en | input | 1 | 1 enables the last data output |
| bck_out | output | 1 | Forwarded bit clock |
| ws_out | output | 1 | Forwarded word select |
| clk_oe | output | 1 | Output enable for bck_out and ws_out |
| sd_out | output | N_OUT | Serial data outputs (identical content) |
| sd_oe | output | N_OUT | Per-output enables for sd_out |

## Verification
Suppose the receiver's bit pointer or channel flag gets out of step. The result then shows up one frame later as a shifted, truncated or swapped word, because the output only replays what was captured one frame earlier. Suppose instead the transmitter's pending-load flag fails. The first bits of the next output slot then carry leftover data, and the fault shows within one slot. A missing clear on a source switch leaves stale samples from the old source in the first output frame after the change. A synchronizer of the wrong depth shows at once as a forwarded clock that is off by a cycle.

// File: rtl/i2s_sw_pkg.sv
package i2s_sw_pkg;
  localparam int LINES = 3;

  typedef struct packed {
    logic bck;
    logic ws;
    logic sd;
  } i2s_lines_t;
endpackage

// File: rtl/i2s_sw_sync.sv
module i2s_sw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2s_sw_rx.sv
module i2s_sw_rx #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bck,
  input  logic              ws,
  input  logic              sd,
  output logic              slot_start,
  output logic              slot_ch,
  output logic              frame_vld,
  output logic [WORD_W-1:0] frm_l,
  output logic [WORD_W-1:0] frm_r
);
  localparam logic [WORD_W-1:0] MSB_ONE = {1'b1, {(WORD_W-1){1'b0}}};

  logic              bck_d, ws_r, primed, started, have_l;
  logic [WORD_W-1:0] acc, pos, cap_l, acc_n;
  logic              rise;

  assign rise  = bck & ~bck_d;
  // pos walks from MSB to LSB; once it is empty further bits are dropped
  assign acc_n = sd ? (acc | pos) : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_d      <= 1'b0;
      ws_r       <= 1'b0;
      primed     <= 1'b0;
      started    <= 1'b0;
      have_l     <= 1'b0;
      acc        <= '0;
      pos        <= MSB_ONE;
      cap_l      <= '0;
      frm_l      <= '0;
      frm_r      <= '0;
      slot_start <= 1'b0;
      slot_ch    <= 1'b0;
      frame_vld  <= 1'b0;
    end else begin
      slot_start <= 1'b0;
      frame_vld  <= 1'b0;
      bck_d      <= bck;
      if (clr) begin
        primed  <= 1'b0;
        started <= 1'b0;
        have_l  <= 1'b0;
        acc     <= '0;
        pos     <= MSB_ONE;
        cap_l   <= '0;
        frm_l   <= '0;
        frm_r   <= '0;
      end else if (rise) begin
        if (!primed) begin
          primed <= 1'b1;
          ws_r   <= ws;
        end else if (ws != ws_r) begin
          // this bit is the LSB slot of the word that just ended
          ws_r       <= ws;
          slot_start <= 1'b1;
          slot_ch    <= ws;
          acc        <= '0;
          pos        <= MSB_ONE;
          started    <= 1'b1;
          if (started) begin
            if (!ws_r) begin
              cap_l  <= acc_n;
              have_l <= 1'b1;
            end else if (have_l) begin
              frm_l     <= cap_l;
              frm_r     <= acc_n;
              frame_vld <= 1'b1;
            end
          end
        end else begin
          acc <= acc_n;
          pos <= pos >> 1;
        end
      end
    end
  end

  // R2
  frame_order_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> (ws_r == 1'b0 && $past(ws_r) == 1'b1));
endmodule

// File: rtl/i2s_sw_tx.sv
module i2s_sw_tx #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bck,
  input  logic              slot_start,
  input  logic              slot_ch,
  input  logic [WORD_W-1:0] frm_l,
  input  logic [WORD_W-1:0] frm_r,
  output logic              sd_q
);
  logic              bck_d, pend, chan, fall;
  logic [WORD_W-1:0] sh, word;

  assign fall = ~bck & bck_d;
  assign word = chan ? frm_r : frm_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_d <= 1'b0;
      pend  <= 1'b0;
      chan  <= 1'b0;
      sh    <= '0;
      sd_q  <= 1'b0;
    end else if (clr) begin
      bck_d <= bck;
      pend  <= 1'b0;
      chan  <= 1'b0;
      sh    <= '0;
      sd_q  <= 1'b0;
    end else begin
      bck_d <= bck;
      if (fall) begin
        if (pend) begin
          sd_q <= word[WORD_W-1];
          sh   <= {word[WORD_W-2:0], 1'b0};
          pend <= 1'b0;
        end else begin
          sd_q <= sh[WORD_W-1];
          sh   <= {sh[WORD_W-2:0], 1'b0};
        end
      end
      if (slot_start) begin
        pend <= 1'b1;
        chan <= slot_ch;
      end
    end
  end
endmodule

// File: rtl/i2s_dual_retx.sv
module i2s_dual_retx
  import i2s_sw_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int SYNC_STAGES = 2,
  parameter int N_OUT       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_a_bck,
  input  logic             src_a_ws,
  input  logic             src_a_sd,
  input  logic             src_b_bck,
  input  logic             src_b_ws,
  input  logic             src_b_sd,
  input  logic             sel_b,
  input  logic             clk_out_dis,
  input  logic             sd_last_en,
  output logic             bck_out,
  output logic             ws_out,
  output logic             clk_oe,
  output logic [N_OUT-1:0] sd_out,
  output logic [N_OUT-1:0] sd_oe
);
  localparam int SRC_LINES = 2 * LINES;

  logic [SRC_LINES-1:0] raw, syncd;
  i2s_lines_t           line_a, line_b, line_sel;
  logic                 sel_q, sel_d, clr;
  logic                 slot_start, slot_ch, frame_vld, sd_q;
  logic [WORD_W-1:0]    frm_l, frm_r;

  assign raw = {src_b_bck, src_b_ws, src_b_sd, src_a_bck, src_a_ws, src_a_sd};

  i2s_sw_sync #(.W(SRC_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syncd)
  );

  assign line_a   = i2s_lines_t'(syncd[LINES-1:0]);
  assign line_b   = i2s_lines_t'(syncd[SRC_LINES-1:LINES]);
  assign line_sel = sel_q ? line_b : line_a;
  assign clr      = sel_q ^ sel_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      sel_d   <= 1'b0;
      bck_out <= 1'b0;
      ws_out  <= 1'b0;
      clk_oe  <= 1'b1;
    end else begin
      sel_q   <= sel_b;
      sel_d   <= sel_q;
      bck_out <= line_sel.bck;
      ws_out  <= line_sel.ws;
      clk_oe  <= ~clk_out_dis;
    end
  end

  i2s_sw_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .clr(clr),
    .bck(line_sel.bck), .ws(line_sel.ws), .sd(line_sel.sd),
    .slot_start(slot_start), .slot_ch(slot_ch), .frame_vld(frame_vld),
    .frm_l(frm_l), .frm_r(frm_r)
  );

  i2s_sw_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .clr(clr), .bck(line_sel.bck),
    .slot_start(slot_start), .slot_ch(slot_ch),
    .frm_l(frm_l), .frm_r(frm_r), .sd_q(sd_q)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic oe_q;
    assign sd_out[i] = sd_q;
    assign sd_oe[i]  = oe_q;
    if (i == N_OUT - 1) begin : g_gated
      always_ff @(posedge clk) begin
        if (rst) oe_q <= 1'b0;
        else     oe_q <= sd_last_en;
      end
    end else begin : g_fixed
      always_ff @(posedge clk) begin
        if (rst) oe_q <= 1'b1;
        else     oe_q <= 1'b1;
      end
    end
  end

  // R3
  sd_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_out[0]) |-> ($fell(bck_out) || $past(clr)));

  // R11
  switch_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (sd_out == '0));

  // R8
  frame_edge_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> $rose(bck_out));
endmodule

// File: tb/i2s_dual_retx_tb.sv
`timescale 1ns/1ps
module i2s_dual_retx_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic src_a_bck = 0, src_a_ws = 0, src_a_sd = 0;
  logic src_b_bck = 0, src_b_ws = 0, src_b_sd = 0;
  logic sel_b = 0, clk_out_dis = 0, sd_last_en = 0;
  logic bck_out, ws_out, clk_oe;
  logic [2:0] sd_out, sd_oe;

  i2s_dual_retx u_dut (
    .clk(clk), .rst(rst),
    .src_a_bck(src_a_bck), .src_a_ws(src_a_ws), .src_a_sd(src_a_sd),
    .src_b_bck(src_b_bck), .src_b_ws(src_b_ws), .src_b_sd(src_b_sd),
    .sel_b(sel_b), .clk_out_dis(clk_out_dis), .sd_last_en(sd_last_en),
    .bck_out(bck_out), .ws_out(ws_out), .clk_oe(clk_oe),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // output-side receiver model
  logic        mon_clr = 1'b1;
  bit          r3_on = 0;
  logic [31:0] out_l [64];
  logic [31:0] out_r [64];
  int nl, nr, r3_viol, r12_viol, midx;
  logic bck_prev, sd_prev, mws, mprim, mstart;
  logic [31:0] macc;

  always @(negedge clk) begin
    if (mon_clr) begin
      nl = 0; nr = 0; r3_viol = 0; r12_viol = 0; midx = 0;
      mprim = 0; mstart = 0; macc = 0; mws = 0;
    end else begin
      if (sd_out[1] !== sd_out[0] || sd_out[2] !== sd_out[0]) r12_viol++;
      if (r3_on && sd_out[0] !== sd_prev && !(bck_prev && !bck_out)) r3_viol++;
      if (bck_out && !bck_prev) begin
        if (!mprim) begin
          mprim = 1; mws = ws_out;
        end else if (ws_out !== mws) begin
          if (midx < 32) macc[31-midx] = sd_out[0];
          if (mstart) begin
            if (mws == 1'b0) begin if (nl < 64) out_l[nl] = macc; nl++; end
            else begin if (nr < 64) out_r[nr] = macc; nr++; end
          end
          mstart = 1; macc = 0; midx = 0; mws = ws_out;
        end else begin
          if (midx < 32) macc[31-midx] = sd_out[0];
          midx++;
        end
      end
    end
    bck_prev = bck_out;
    sd_prev  = sd_out[0];
  end

  task automatic do_reset(input logic src);
    @(negedge clk);
    mon_clr = 1; rst = 1; sel_b = src; clk_out_dis = 0; sd_last_en = 0; r3_on = 0;
    src_a_bck = 0; src_a_ws = 0; src_a_sd = 0;
    src_b_bck = 0; src_b_ws = 0; src_b_sd = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    mon_clr = 0;
  endtask

  task automatic drive_slot(input logic ch, input logic [31:0] wa, input logic [31:0] wb,
                            input logic pa, input logic pb, input int nb, input int h, input bit sw);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      src_a_bck = 0; src_b_bck = 0;
      src_a_ws = ch; src_b_ws = ch;
      src_a_sd = (i == 0) ? pa : wa[nb-i];
      src_b_sd = (i == 0) ? pb : wb[nb-i];
      if (sw && i == nb/2) sel_b = 1;
      repeat (h) @(negedge clk);
      src_a_bck = 1; src_b_bck = 1;
      repeat (h-1) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input int nb);
    logic [17:0] v;
    if (nb >= 18) v = 18'(w >> (nb - 18));
    else          v = 18'(w << (18 - nb));
    return {v, 14'b0};
  endfunction

  // src: initial selection; swk: frame index at which new source data first lands (-1: none)
  task automatic run_stream(input string tag, input logic src, input int nb, input int h,
                            input int nfr, input int swk);
    logic [31:0] al [8];
    logic [31:0] ar [8];
    logic [31:0] bl [8];
    logic [31:0] br [8];
    logic [31:0] mask, el, er;
    logic pa, pb;
    bit use_b;
    mask = (32'h1 << nb) - 1;
    for (int j = 0; j < nfr; j++) begin
      al[j] = (32'h5A3C96E1 * (j + 1) + nb) & mask;
      ar[j] = (32'h1B873D29 * (j + 3)) & mask;
      bl[j] = al[j] ^ mask;
      br[j] = (ar[j] ^ 32'h00F0F0F) & mask;
    end
    do_reset(src);
    r3_on = (swk < 0);
    drive_slot(1'b1, 0, 0, 1'b0, 1'b0, nb, h, 1'b0);
    pa = 0; pb = 0;
    for (int j = 0; j < nfr; j++) begin
      drive_slot(1'b0, al[j], bl[j], pa, pb, nb, h, 1'b0);
      pa = al[j][0]; pb = bl[j][0];
      drive_slot(1'b1, ar[j], br[j], pa, pb, nb, h, (swk == j + 1));
      pa = ar[j][0]; pb = br[j][0];
    end
    drive_slot(1'b0, 0, 0, pa, pb, nb, h, 1'b0);
    drive_slot(1'b1, 0, 0, 1'b0, 1'b0, nb, h, 1'b0);
    repeat (10) @(negedge clk);
    chk(nl >= nfr && nr >= nfr, {tag, " R2 word count"}, 32'(nl), 32'(nfr));
    for (int j = 0; j < nfr; j++) begin
      use_b = (swk >= 0) ? (j > swk) : src;
      if (j == 0 || (swk >= 0 && j == swk)) begin
        el = 0; er = 0;
      end else begin
        el = expect_word(use_b ? bl[j-1] : al[j-1], nb);
        er = expect_word(use_b ? br[j-1] : ar[j-1], nb);
      end
      chk(out_l[j] === el, $sformatf("%s R2 R8 left frame %0d", tag, j), out_l[j], el);
      if (!(swk >= 0 && j == swk - 1))
        chk(out_r[j] === er, $sformatf("%s R2 R8 right frame %0d", tag, j), out_r[j], er);
    end
    if (swk < 0) chk(r3_viol == 0, {tag, " R3 data moved off falling edge"}, 32'(r3_viol), 0);
    chk(r12_viol == 0, {tag, " R12 outputs differ"}, 32'(r12_viol), 0);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk(clk_oe === 1'b1, "R1 clk_oe", 32'(clk_oe), 1);
    chk(sd_oe === 3'b011, "R1 sd_oe", 32'(sd_oe), 3);
    chk(sd_out === 3'b000, "R1 sd_out", 32'(sd_out), 0);
    chk(bck_out === 1'b0 && ws_out === 1'b0, "R1 clocks idle", {30'b0, bck_out, ws_out}, 0);
  endtask

  task automatic t_follow();
    do_reset(1'b0);
    src_a_bck = 1; src_a_ws = 0; src_b_bck = 0; src_b_ws = 1;
    repeat (2) @(negedge clk);
    chk(bck_out === 1'b0, "R7 latency not yet 3", 32'(bck_out), 0);
    @(negedge clk);
    chk(bck_out === 1'b1 && ws_out === 1'b0, "R7 follows A after 3", {30'b0, bck_out, ws_out}, 2);
    sel_b = 1;
    repeat (4) @(negedge clk);
    chk(bck_out === 1'b0 && ws_out === 1'b1, "R6 R7 follows B", {30'b0, bck_out, ws_out}, 1);
  endtask

  task automatic t_enables();
    do_reset(1'b0);
    clk_out_dis = 1;
    @(negedge clk);
    chk(clk_oe === 1'b0, "R9 disable", 32'(clk_oe), 0);
    clk_out_dis = 0;
    @(negedge clk);
    chk(clk_oe === 1'b1, "R9 re-enable", 32'(clk_oe), 1);
    sd_last_en = 1;
    @(negedge clk);
    chk(sd_oe === 3'b111, "R10 enable third", 32'(sd_oe), 7);
    sd_last_en = 0;
    @(negedge clk);
    chk(sd_oe === 3'b011, "R10 disable third", 32'(sd_oe), 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_stream("short16", 1'b0, 16, 4, 6, -1);   // R4
    run_stream("long24",  1'b0, 24, 4, 6, -1);   // R5
    run_stream("exact18_ratio4", 1'b0, 18, 2, 6, -1); // R13
    run_stream("srcB20",  1'b1, 20, 4, 6, -1);   // R6
    run_stream("switch",  1'b0, 18, 4, 6, 3);    // R11
    t_follow();
    t_enables();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule